// File: doc/BRIEF.md
# PCM TDM Transmit Slot Inserter

This block puts one voice channel's PCM word onto a serial time-division transmit line that many channels share. A frame has 128 slots of 8 bit clocks each. A one-cycle frame sync pulse marks the first bit of slot 0. The block counts bits and slots from that pulse. It compares the current slot with a programmed slot number and shifts the channel's byte out, most significant bit first, only while it owns that slot. The line is shared, so the block also drives an output-enable. Outside its slots it lowers the enable, and the pad logic around it leaves the line floating.

Software sets an 8-bit slot word. Its top bit arms the channel and its lower seven bits select the slot. A mode input picks between two sizes. In compressed mode one byte goes out in one slot. In linear mode a 16-bit sample goes out as two bytes, high byte in the chosen slot and low byte in the slot after it. When the chosen slot is 127, that following slot is slot 0 of the next frame. The sample is captured at each frame sync, so the bytes of one frame always come from one consistent word.

Top module: `pcm_slot_tx`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `txEn` and `txData` are both 0.
- R2: Until the first frame sync after reset is seen, `txEn` stays 0 whatever the slot word holds.
- R3: A frame sync sampled high at a rising edge makes the cycle that follows bit 0 of slot 0. Each slot is 8 cycles long, a frame is 1024 cycles, and the slot count wraps from 127 back to 0.
- R4: When bit 7 of `slotCfg` is 0, `txEn` stays 0 for the whole frame.
- R5: When bit 7 of `slotCfg` is 1 and `linearMode` is 0, `txEn` is 1 for exactly the 8 cycles of slot `slotCfg[6:0]`. In those cycles `txData` carries `sample[15:8]`, bit 15 first.
- R6: When bit 7 of `slotCfg` is 1 and `linearMode` is 1, the high byte `sample[15:8]` goes out in the programmed slot. The low byte `sample[7:0]` then goes out, MSB first, in the next slot, with `txEn` high for both 8-cycle runs.
- R7: In linear mode with slot 127 programmed, the low byte goes out in slot 0 of the next frame. It is the low byte of the word captured in the previous frame. No low byte is sent in slot 0 of the first frame after reset.
- R8: `sample` is captured only at a frame sync. Changes to it at other times do not alter the bits sent in that frame.
- R9: `txData` is 0 in every cycle where `txEn` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; outputs change on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| frameSync | input | 1 | One-cycle pulse marking bit 0 of slot 0 |
| slotCfg | input | 8 | Bit 7 arms the channel; bits 6..0 give the slot number |
| linearMode | input | 1 | 1 = 16-bit sample over two slots; 0 = one byte |
| sample | input | 16 | Channel sample word |
| txData | output | 1 | Serial transmit bit |
| txEn | output | 1 | High while the channel drives the line |

## Verification
A wrong bit or slot count shows at once as a `txEn` run that starts or ends on the wrong cycle. It appears within the first frame, at most 1024 cycles after the sync. A bad byte select or a bad sample capture shows as a wrong bit inside an otherwise correctly placed run. A stale hold of the low byte shows only in slot 0 of the second frame, so runs with slot 127 in linear mode must cover two frame syncs. Every cycle of every frame is compared against a position count kept in the bench, over all enable and mode settings and over the slots at both ends of the range.

// File: rtl/pcm_slot_tx_pkg.sv
package pcm_slot_tx_pkg;
  // Strobes from the slot control to the shift datapath, all valid for the
  // cycle that begins at the next rising edge.
  typedef struct packed {
    logic latchWord;  // capture the incoming sample (frame sync)
    logic loadHold;   // refresh the wrap-around low-byte copy
    logic active;     // channel owns the next bit time
    logic lowByte;    // next bit comes from the low byte
    logic fromHold;   // low byte comes from the held copy (slot 0 wrap)
  } txStrobe_t;
endpackage

// File: rtl/pcm_slot_tx_ctl.sv
module pcm_slot_tx_ctl
  import pcm_slot_tx_pkg::*;
#(
  parameter int SLOT_BITS = 8,
  parameter int SLOTS     = 128,   // power of two
  localparam int BIT_W    = $clog2(SLOT_BITS),
  localparam int IDX_W    = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frameSync,
  input  logic [IDX_W:0]   slotCfg,
  input  logic             linearMode,
  output txStrobe_t        strb,
  output logic [BIT_W-1:0] bitIdx
);
  logic [IDX_W-1:0] slotQ, slotN;
  logic [BIT_W-1:0] bitQ, bitN;
  logic syncedQ, syncedN, primedQ, primedN;
  logic [IDX_W-1:0] tsSel, tsAfter;
  logic armed, inHi, inLo, wraps;

  assign tsSel   = slotCfg[IDX_W-1:0];
  assign armed   = slotCfg[IDX_W];
  assign tsAfter = tsSel + IDX_W'(1);

  always_comb begin
    if (frameSync) begin
      slotN = '0;
      bitN  = '0;
    end else if (bitQ == BIT_W'(SLOT_BITS - 1)) begin
      slotN = slotQ + IDX_W'(1);
      bitN  = '0;
    end else begin
      slotN = slotQ;
      bitN  = bitQ + BIT_W'(1);
    end
  end

  assign syncedN = syncedQ | frameSync;
  // A wrapped low byte is only valid once a full frame has been latched.
  assign primedN = primedQ | (syncedQ && slotN == '0 && bitN == '0);

  assign inHi  = (slotN == tsSel);
  assign inLo  = linearMode && (slotN == tsAfter);
  assign wraps = inLo && (tsSel == '1);

  always_comb begin
    strb.latchWord = frameSync;
    strb.loadHold  = frameSync || (slotN != '0);
    strb.active    = syncedN && armed && (inHi || (inLo && (!wraps || primedN)));
    strb.lowByte   = inLo;
    strb.fromHold  = wraps;
  end
  assign bitIdx = bitN;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slotQ   <= '0;
      bitQ    <= '0;
      syncedQ <= 1'b0;
      primedQ <= 1'b0;
    end else begin
      slotQ   <= slotN;
      bitQ    <= bitN;
      syncedQ <= syncedN;
      primedQ <= primedN;
    end
  end
endmodule

// File: rtl/pcm_slot_tx_dp.sv
module pcm_slot_tx_dp
  import pcm_slot_tx_pkg::*;
#(
  parameter int SLOT_BITS = 8,
  localparam int BIT_W    = $clog2(SLOT_BITS),
  localparam int WORD_W   = 2 * SLOT_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] sample,
  input  txStrobe_t         strb,
  input  logic [BIT_W-1:0]  bitIdx,
  output logic              txData,
  output logic              txEn
);
  logic [WORD_W-1:0]    wordQ, wordN;
  logic [SLOT_BITS-1:0] holdQ, holdN, lowSrc, curByte;
  logic                 nextBit;

  assign wordN   = strb.latchWord ? sample : wordQ;
  assign holdN   = strb.loadHold ? wordQ[SLOT_BITS-1:0] : holdQ;
  assign lowSrc  = strb.fromHold ? holdN : wordN[SLOT_BITS-1:0];
  assign curByte = strb.lowByte ? lowSrc : wordN[WORD_W-1:SLOT_BITS];
  assign nextBit = curByte[BIT_W'(SLOT_BITS - 1) - bitIdx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wordQ  <= '0;
      holdQ  <= '0;
      txData <= 1'b0;
      txEn   <= 1'b0;
    end else begin
      wordQ  <= wordN;
      holdQ  <= holdN;
      txEn   <= strb.active;
      txData <= strb.active & nextBit;
    end
  end
endmodule

// File: rtl/pcm_slot_tx.sv
module pcm_slot_tx
  import pcm_slot_tx_pkg::*;
#(
  parameter int SLOT_BITS = 8,
  parameter int SLOTS     = 128,
  localparam int BIT_W    = $clog2(SLOT_BITS),
  localparam int IDX_W    = $clog2(SLOTS),
  localparam int WORD_W   = 2 * SLOT_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frameSync,
  input  logic [IDX_W:0]    slotCfg,
  input  logic              linearMode,
  input  logic [WORD_W-1:0] sample,
  output logic              txData,
  output logic              txEn
);
  txStrobe_t        strb;
  logic [BIT_W-1:0] bitIdx;

  pcm_slot_tx_ctl #(.SLOT_BITS(SLOT_BITS), .SLOTS(SLOTS)) u_ctl (
    .clk(clk), .rst_n(rst_n), .frameSync(frameSync), .slotCfg(slotCfg),
    .linearMode(linearMode), .strb(strb), .bitIdx(bitIdx)
  );

  pcm_slot_tx_dp #(.SLOT_BITS(SLOT_BITS)) u_dp (
    .clk(clk), .rst_n(rst_n), .sample(sample), .strb(strb),
    .bitIdx(bitIdx), .txData(txData), .txEn(txEn)
  );
endmodule

// File: rtl/pcm_slot_tx_chk.sv
module pcm_slot_tx_chk #(
  parameter int SLOT_BITS = 8,
  parameter int SLOTS     = 128,
  localparam int IDX_W    = $clog2(SLOTS)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           frameSync,
  input logic [IDX_W:0] slotCfg,
  input logic           txData,
  input logic           txEn
);
  logic seenSync;
  int   runLen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seenSync <= 1'b0;
      runLen   <= 0;
    end else begin
      seenSync <= seenSync | frameSync;
      runLen   <= txEn ? runLen + 1 : 0;
    end
  end

  p_quiet_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !txEn |-> !txData);

  p_no_sync_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !seenSync |-> !txEn);

  p_disarmed_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !slotCfg[IDX_W] |=> !txEn);

  p_slot0_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frameSync && slotCfg == {1'b1, {IDX_W{1'b0}}}) |=> txEn);

  p_burst_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    runLen <= 2 * SLOT_BITS);
endmodule

bind pcm_slot_tx pcm_slot_tx_chk #(.SLOT_BITS(SLOT_BITS), .SLOTS(SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .frameSync(frameSync), .slotCfg(slotCfg),
  .txData(txData), .txEn(txEn)
);

// File: tb/pcm_slot_tx_test.sv
`timescale 1ns/1ps
module pcm_slot_tx_test;
  localparam int SB = 8;
  localparam int NS = 128;
  localparam int FL = SB * NS;

  logic clk = 1'b0, rst_n = 1'b0, frameSync = 1'b0, linearMode = 1'b0;
  logic [7:0]  slotCfg = 8'h00;
  logic [15:0] sample = 16'h0000;
  logic txData, txEn;

  int nRun = 0, nFail = 0, cyc = 0;
  logic [15:0] curWord;
  logic [7:0]  prevLow;
  int framesSeen, pos;

  always #2.5 clk = ~clk;

  pcm_slot_tx uut (.clk(clk), .rst_n(rst_n), .frameSync(frameSync),
    .slotCfg(slotCfg), .linearMode(linearMode), .sample(sample),
    .txData(txData), .txEn(txEn));

  function automatic logic [15:0] smp(input int c);
    return 16'hB4E1 ^ 16'(c * 977) ^ 16'(c >> 3);
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %b expected %b (pos %0d)", tag, act, exp, pos);
    end
  endtask

  task automatic step(input bit fsv, input bit en, input int ts, input bit lin);
    int slot, b;
    bit hi, lo, wrp, act;
    logic [7:0] byt;
    logic expD;
    string tag;
    @(negedge clk);
    frameSync = fsv;
    sample = smp(cyc);
    cyc++;
    @(posedge clk);
    if (fsv) begin
      prevLow = curWord[7:0];
      curWord = sample;
      framesSeen++;
      pos = 0;
    end else if (framesSeen > 0) pos = (pos + 1) % FL;
    #1;
    slot = pos / SB;
    b = pos % SB;
    hi = (slot == ts);
    lo = lin && (slot == (ts + 1) % NS);
    wrp = lo && (ts == NS - 1);
    act = (framesSeen > 0) && en && (hi || (lo && (!wrp || framesSeen >= 2)));
    byt = hi ? curWord[15:8] : (wrp ? prevLow : curWord[7:0]);
    expD = act ? byt[7 - b] : 1'b0;
    if (framesSeen == 0) tag = "R2";
    else if (!en) tag = "R4";
    else if (wrp) tag = "R7 R8";
    else if (lo) tag = "R6 R8";
    else if (hi) tag = (slot == 0) ? "R3 R5 R8" : "R5 R8";
    else tag = "R5 R3";
    check(tag, txEn, act);
    check(act ? tag : "R9", txData, expD);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    int tsList[5] = '{0, 1, 63, 126, 127};
    // R1: reset state
    slotCfg = 8'h80;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", txEn, 1'b0);
    check("R1", txData, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", txEn, 1'b0);
    check("R1", txData, 1'b0);

    for (int en = 0; en < 2; en++)
      for (int lin = 0; lin < 2; lin++)
        for (int ti = 0; ti < 5; ti++) begin
          @(negedge clk);
          rst_n = 1'b0;
          frameSync = 1'b0;
          slotCfg = {en[0], 7'(tsList[ti])};
          linearMode = lin[0];
          repeat (2) @(negedge clk);
          rst_n = 1'b1;
          framesSeen = 0;
          pos = 0;
          curWord = '0;
          prevLow = '0;
          for (int k = 0; k < 10; k++) step(1'b0, en[0], tsList[ti], lin[0]);
          for (int f = 0; f < 3; f++)
            for (int k = 0; k < FL; k++)
              step(k == 0, en[0], tsList[ti], lin[0]);
        end

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule